// File: doc/BRIEF.md
# One-Hot Memory Bank Select Register

This block decides whether one memory board answers processor memory cycles, so that as many as eight boards can share a single address space. It watches processor output (I/O write) cycles. When a write is aimed at the fixed bank-select port, it captures the data byte into a select register. A board number from 0 to 7, set by static configuration inputs, picks one bit of that register. When the picked bit is set, the board-enable output is high and the board may respond to memory reads and writes.

Software chooses a board by writing a byte with only that board's bit set. For example, 0x01 picks board 0, 0x20 picks board 5 and 0x80 picks board 7. Reset leaves the register holding 0x01, so a board numbered 0 is live without any port write. Boards that are not selected still keep their contents. Only their response to bus cycles is held off. A second, active-low output mirrors the enable, so that other peripherals can follow the bank selection.

Top module: `bank_select`

## Requirements
- R1: While reset is high, and after it falls with no later port write, the select register holds 0x01. The enable is high only when the configured board number is 0, and low for board numbers 1 to 7.
- R2: A clock edge that sees `io_wr` high together with `io_addr` equal to 0x40 loads `io_wdata` into the select register. The enable reflects the new byte from just after that edge.
- R3: Writes to any other port address, and cycles with `io_wr` low at port 0x40, leave the select register unchanged.
- R4: The enable equals bit n of the select register, where n is the configured board number. Bit 0 is the least significant bit, so byte 0x01 enables board 0, 0x20 enables board 5 and 0x80 enables board 7.
- R5: A byte with several bits set enables every board whose bit is set. Byte 0x00 disables all boards, and byte 0xFF enables all boards.
- R6: A change of the configured board number changes the enable in the same cycle, with no clock edge needed.
- R7: `board_en_n` is always the logical inverse of `board_en`.
- R8: With no qualifying write, the select register keeps its value for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high power-on clear |
| io_wr | input | 1 | I/O write cycle qualifier, sampled on the rising edge |
| io_addr | input | 8 | I/O port address of the write |
| io_wdata | input | 8 | Data byte of the I/O write |
| bank_id | input | 3 | Configured board number, 0 to 7 |
| board_en | output | 1 | High when this board answers memory cycles |
| board_en_n | output | 1 | Inverted copy of `board_en` for other peripherals |

## Verification
A wrong stored bit shows at `board_en` as soon as the configured board number points at that bit, because the output is a pure selection from the register with no further delay. Sweeping all eight board numbers after every one of the 256 written bytes therefore exposes any corrupted, swapped or stuck register bit at the next sample after the capturing edge. A register that fails to hold, or that loads from a wrong port, shows as an enable that differs from the last legal byte written. A wrong reset pattern, such as bit 0 stored uninverted, shows directly after reset as board 0 disabled.

// File: rtl/bank_select_pkg.sv
package bank_select_pkg;

    // Default geometry of the select port
    localparam int IO_ADDR_W    = 8;
    localparam int SEL_W        = 8;
    localparam int BANK_W       = $clog2(SEL_W);
    localparam logic [IO_ADDR_W-1:0] SEL_PORT_DEF  = 8'h40;
    localparam logic [SEL_W-1:0]     SEL_RESET_DEF = 8'h01;

    // One processor output cycle as seen by the block
    typedef struct packed {
        logic                 wr;
        logic [IO_ADDR_W-1:0] addr;
        logic [SEL_W-1:0]     data;
    } io_cycle_t;

    // True when the cycle is a write to the given port
    function automatic logic hits_port(input io_cycle_t cyc,
                                       input logic [IO_ADDR_W-1:0] port);
        return cyc.wr && (cyc.addr == port);
    endfunction

endpackage

// File: rtl/sel_port_decode.sv
module sel_port_decode #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] PORT = 8'h40
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              load
);
    always_comb begin
        load = wr && (addr == PORT);
    end
endmodule

// File: rtl/sel_store.sv
module sel_store #(
    parameter int SEL_W = 8,
    parameter logic [SEL_W-1:0] RST_VAL = 8'h01
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SEL_W-1:0] din,
    output logic [SEL_W-1:0] dout
);
    // Every bit clears to zero in the flop. Bits whose reset value is 1
    // are kept inverted, so a cleared flop reads back as the reset value.
    for (genvar i = 0; i < SEL_W; i++) begin : g_bit
        logic q;
        if (RST_VAL[i]) begin : g_inv
            always_ff @(posedge clk) begin
                if (rst)       q <= 1'b0;
                else if (load) q <= ~din[i];
            end
            assign dout[i] = ~q;
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)       q <= 1'b0;
                else if (load) q <= din[i];
            end
            assign dout[i] = q;
        end
    end
endmodule

// File: rtl/bank_pick.sv
module bank_pick #(
    parameter int SEL_W  = 8,
    parameter int BANK_W = $clog2(SEL_W)
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [BANK_W-1:0] bank,
    output logic              en
);
    always_comb begin
        en = 1'b0;
        for (int i = 0; i < SEL_W; i++) begin
            if (bank == BANK_W'(i)) en = sel[i];
        end
    end
endmodule

// File: rtl/bank_select.sv
module bank_select
    import bank_select_pkg::*;
#(
    parameter int ADDR_W = IO_ADDR_W,
    parameter int DATA_W = SEL_W,
    parameter logic [ADDR_W-1:0] PORT = SEL_PORT_DEF,
    parameter logic [DATA_W-1:0] RESET_SEL = SEL_RESET_DEF,
    localparam int ID_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic [ID_W-1:0]   bank_id,
    output logic              board_en,
    output logic              board_en_n
);
    logic              load;
    logic [DATA_W-1:0] sel_q;
    logic              en;

    sel_port_decode #(.ADDR_W(ADDR_W), .PORT(PORT)) u_dec (
        .wr   (io_wr),
        .addr (io_addr),
        .load (load)
    );

    sel_store #(.SEL_W(DATA_W), .RST_VAL(RESET_SEL)) u_store (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .din  (io_wdata),
        .dout (sel_q)
    );

    bank_pick #(.SEL_W(DATA_W), .BANK_W(ID_W)) u_pick (
        .sel  (sel_q),
        .bank (bank_id),
        .en   (en)
    );

    assign board_en   = en;
    assign board_en_n = ~en;
endmodule

// File: rtl/bank_select_chk.sv
module bank_select_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] PORT = 8'h40,
    parameter logic [DATA_W-1:0] RESET_SEL = 8'h01
) (
    input logic              clk,
    input logic              rst,
    input logic              io_wr,
    input logic [ADDR_W-1:0] io_addr,
    input logic [DATA_W-1:0] io_wdata,
    input logic              board_en,
    input logic              board_en_n,
    input logic [DATA_W-1:0] sel_q
);
    logic rst_seen_q;
    logic armed_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        armed_q    <= rst_seen_q && !rst ? 1'b1 : (rst ? 1'b0 : armed_q);
    end

    // R1
    always @(posedge clk) begin
        if (rst_seen_q === 1'b1 && rst === 1'b1) begin
            reset_value_chk: assert (sel_q == RESET_SEL);
        end
    end

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (io_wr && io_addr == PORT) |=> (sel_q == $past(io_wdata)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !(io_wr && io_addr == PORT) |=> $stable(sel_q));

    // R5
    none_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (sel_q == '0) |-> !board_en);

    // R5
    all_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (sel_q == '1) |-> board_en);

    // R7
    always @(posedge clk) begin
        if (armed_q === 1'b1) begin
            pin_chk: assert (board_en_n == !board_en);
        end
    end
endmodule

bind bank_select bank_select_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT(PORT), .RESET_SEL(RESET_SEL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_wr      (io_wr),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .board_en   (board_en),
    .board_en_n (board_en_n),
    .sel_q      (sel_q)
);

// File: tb/bank_select_bench.sv
`timescale 1ns/1ps
module bank_select_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic [7:0] io_wdata = 8'h00;
    logic [2:0] bank_id = 3'd0;
    logic       board_en;
    logic       board_en_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bank_select u_bank_select (
        .clk        (clk),
        .rst        (rst),
        .io_wr      (io_wr),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .bank_id    (bank_id),
        .board_en   (board_en),
        .board_en_n (board_en_n)
    );

    task automatic check(input logic got, input logic exp, input string req,
                         input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic write_port(input logic [7:0] addr, input logic [7:0] data,
                              input logic wr);
        @(negedge clk);
        io_wr = wr; io_addr = addr; io_wdata = data;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 8'h00; io_wdata = 8'h00;
    endtask

    // Sweep all board numbers against an expected register byte
    task automatic sweep(input logic [7:0] exp_byte, input string req);
        for (int b = 0; b < 8; b++) begin
            bank_id = 3'(b);
            #1;
            check(board_en, exp_byte[b], req, $sformatf("byte %02h bank %0d", exp_byte, b));
            check(board_en_n, ~exp_byte[b], "R7", $sformatf("inverse pin bank %0d", b));
        end
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        sweep(8'h01, "R1");
        rst = 1'b0;
        @(negedge clk);
        sweep(8'h01, "R1");
    endtask

    task automatic t_all_bytes();
        for (int v = 0; v < 256; v++) begin
            write_port(8'h40, 8'(v), 1'b1);
            sweep(8'(v), "R4");
        end
    endtask

    task automatic t_named_bytes();
        write_port(8'h40, 8'h20, 1'b1);
        bank_id = 3'd5; #1;
        check(board_en, 1'b1, "R2", "0x20 enables bank 5");
        write_port(8'h40, 8'h80, 1'b1);
        bank_id = 3'd7; #1;
        check(board_en, 1'b1, "R2", "0x80 enables bank 7");
        write_port(8'h40, 8'h00, 1'b1);
        sweep(8'h00, "R5");
        write_port(8'h40, 8'hA5, 1'b1);
        sweep(8'hA5, "R5");
        write_port(8'h40, 8'hFF, 1'b1);
        sweep(8'hFF, "R5");
    endtask

    task automatic t_ignored_writes();
        write_port(8'h40, 8'h20, 1'b1);
        write_port(8'h41, 8'h01, 1'b1);
        write_port(8'h3F, 8'h01, 1'b1);
        write_port(8'hC0, 8'h01, 1'b1);
        write_port(8'h00, 8'hFF, 1'b1);
        write_port(8'h40, 8'h01, 1'b0);
        sweep(8'h20, "R3");
    endtask

    task automatic t_live_bank_change();
        write_port(8'h40, 8'h0C, 1'b1);
        @(negedge clk);
        bank_id = 3'd2; #1;
        check(board_en, 1'b1, "R6", "bank 2 without edge");
        bank_id = 3'd1; #1;
        check(board_en, 1'b0, "R6", "bank 1 without edge");
        bank_id = 3'd3; #1;
        check(board_en, 1'b1, "R6", "bank 3 without edge");
    endtask

    task automatic t_retention();
        write_port(8'h40, 8'h42, 1'b1);
        repeat (60) @(negedge clk);
        sweep(8'h42, "R8");
    endtask

    task automatic t_reset_mid_run();
        write_port(8'h40, 8'h80, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        sweep(8'h01, "R1");
    endtask

    initial begin
        t_reset_state();
        t_named_bytes();
        t_ignored_writes();
        t_live_bank_change();
        t_retention();
        t_all_bytes();
        t_reset_mid_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule